// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow N Divider

This block divides a fast input clock by a programmable ratio N = B·P + A and emits one single-cycle pulse per N input cycles. That pulse is the feedback clock that a phase/frequency detector compares against a reference. Inside, a dual-modulus prescaler model divides by P+1 while swallow counts remain and by P otherwise. A B counter counts completed prescaler periods. The low modulus P is chosen from four pairs: 8/9, 16/17, 32/33 and 64/65.

The ratio settings arrive as static inputs from programming latches. They are sampled only at the edge that ends an output period, so a change made mid-period never shortens or stretches the period in progress. A setting with fewer B periods than swallow counts, or with B below 3, cannot be built. Such a setting raises a flag and holds the feedback output low. The block keeps re-sampling it on every clock until a legal one appears.

A second, independent divider counts reference-input events (qualified by an enable in the same clock domain) and emits the comparison-side pulse once every R events. A divide value of zero is treated as one.

Top module: `pulse_swallow_div`

## Requirements
- R1: With a legal setting, fb_pulse is high for exactly one clock cycle, and successive pulses are exactly N = B·P + A clock edges apart.
- R2: psel selects the low modulus P: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. The high modulus is P+1.
- R3: The swallow count A is 6 bits (0 to 63) and the B count is 12 bits (3 to 4095). The extreme A=63, B=4095 divides correctly.
- R4: div_a, div_b and psel are sampled only at a boundary edge: the edge that raises fb_pulse, or any edge while no legal setting is active. The next pulse follows the sampled setting N edges later, and changes between boundaries have no effect on the current period.
- R5: A setting with B < A or B < 3, sampled at a boundary, sets cfg_bad at that edge and keeps fb_pulse low. Such a setting is re-sampled on every following edge. The first legal sample clears cfg_bad, and the first pulse follows N edges after that sample.
- R6: While rst_n is low, fb_pulse, ref_pulse and cfg_bad are low. The first edge with rst_n high is a boundary edge.
- R7: ref_pulse goes high for one cycle at the edge that accepts the R-th ref_tick since reset or since the previous ref_pulse, where R is ref_div.
- R8: ref_div equal to zero divides by one: every ref_tick produces a ref_pulse.
- R9: With A = 0 every prescaler period uses modulus P, giving N = B·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 2 | Prescaler modulus pair select |
| div_a | input | 6 | Swallow count A |
| div_b | input | 12 | Prescaler period count B |
| ref_div | input | 14 | Reference divide value R |
| ref_tick | input | 1 | Reference-input event qualifier |
| fb_pulse | output | 1 | Feedback pulse, once per N clocks |
| ref_pulse | output | 1 | Reference comparison pulse, once per R ticks |
| cfg_bad | output | 1 | Sampled ratio setting is illegal |

## Verification
Two things can fall on the same edge: the end of an output period and the sampling of a new ratio setting. The sample may also be an illegal one that has to suppress the pulse. The bench provokes this by watching its own behavioural model. It changes div_a, div_b and psel in the cycle just before a pulse is due, once to a legal value and once to an illegal one. It also changes them in the middle of periods. A cycle-by-cycle model built from integers decides the expected output on every edge. Its rules are that the setting present at the pulse edge defines the next period, and that an illegal setting drops that edge's pulse and raises cfg_bad.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    PSC_8_9   = 2'd0,
    PSC_16_17 = 2'd1,
    PSC_32_33 = 2'd2,
    PSC_64_65 = 2'd3
  } psc_sel_e;

  // width of the prescaler cycle counter (holds up to the largest high modulus - 1)
  localparam int PSC_CNT_W = 7;

  function automatic logic [PSC_CNT_W-1:0] psc_low_mod(input psc_sel_e sel);
    logic [PSC_CNT_W-1:0] base;
    base = PSC_CNT_W'(8);
    return base << sel;
  endfunction

endpackage

// File: rtl/pss_prescaler.sv
module pss_prescaler #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] mod_m1,
  output logic             wrap
);

  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] pcnt_d;
  logic             pcnt_en;

  always_comb begin
    pcnt_en = load || (pcnt_q != '0);
    if (load) pcnt_d = mod_m1;
    else      pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  assign wrap = (pcnt_q == '0);

  // R2
  psc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pcnt_q == $past(mod_m1)));

  // R1
  psc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wrap) |=> (pcnt_q == $past(pcnt_q) - 1'b1));

endmodule

// File: rtl/pss_swallow_ctrl.sv
module pss_swallow_ctrl #(
  parameter int A_W   = 6,
  parameter int B_W   = 12,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             run,
  input  logic [A_W-1:0]   cap_a,
  input  logic [B_W-1:0]   cap_b,
  input  logic [CNT_W-1:0] cap_p,
  input  logic             psc_wrap,
  output logic             psc_load,
  output logic [CNT_W-1:0] psc_mod_m1,
  output logic             period_end
);

  localparam logic [B_W-1:0] B_ONE = B_W'(1);
  localparam int             A_PAD = B_W - A_W;

  logic [A_W-1:0]   a_rem_q, a_rem_d;
  logic [B_W-1:0]   b_rem_q, b_rem_d;
  logic [CNT_W-1:0] p_low_q, p_low_d;
  logic             cnt_en;
  logic             step;
  logic [A_W-1:0]   a_step;

  always_comb begin
    step       = run && psc_wrap;
    period_end = step && (b_rem_q == B_ONE);
    a_step     = (a_rem_q != '0) ? a_rem_q - 1'b1 : '0;

    cnt_en     = capture || step;
    a_rem_d    = a_rem_q;
    b_rem_d    = b_rem_q;
    p_low_d    = p_low_q;
    psc_load   = 1'b0;
    psc_mod_m1 = '0;

    if (capture) begin
      a_rem_d    = cap_a;
      b_rem_d    = cap_b;
      p_low_d    = cap_p;
      psc_load   = 1'b1;
      psc_mod_m1 = (cap_a != '0) ? cap_p : cap_p - 1'b1;
    end else if (step) begin
      a_rem_d    = a_step;
      b_rem_d    = b_rem_q - 1'b1;
      psc_load   = 1'b1;
      psc_mod_m1 = (a_step != '0) ? p_low_q : p_low_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem_q <= '0;
      b_rem_q <= '0;
      p_low_q <= '0;
    end else if (cnt_en) begin
      a_rem_q <= a_rem_d;
      b_rem_q <= b_rem_d;
      p_low_q <= p_low_d;
    end
  end

  // R1
  swallow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({{A_PAD{1'b0}}, a_rem_q} <= b_rem_q));

  // R1
  b_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (b_rem_q != '0));

  // R4
  modulus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(p_low_q));

endmodule

// File: rtl/pss_ref_div.sv
module pss_ref_div #(
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_tick,
  input  logic [R_W-1:0] ref_div,
  output logic           ref_pulse
);

  logic [R_W-1:0] rcnt_q, rcnt_d;
  logic [R_W:0]   rcnt_inc;
  logic [R_W:0]   r_eff;
  logic           hit;
  logic           pulse_d;

  always_comb begin
    r_eff    = (ref_div == '0) ? (R_W+1)'(1) : {1'b0, ref_div};
    rcnt_inc = {1'b0, rcnt_q} + 1'b1;
    hit      = ref_tick && (rcnt_inc >= r_eff);
    pulse_d  = hit;
    if (hit) rcnt_d = '0;
    else     rcnt_d = rcnt_inc[R_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rcnt_q <= '0;
    else if (ref_tick) rcnt_q <= rcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_pulse <= 1'b0;
    else        ref_pulse <= pulse_d;
  end

  // R7
  ref_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick));

  // R8
  ref_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && ref_div == '0) |=> ref_pulse);

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pss_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 12,
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     psel,
  input  logic [A_W-1:0] div_a,
  input  logic [B_W-1:0] div_b,
  input  logic [R_W-1:0] ref_div,
  input  logic           ref_tick,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           cfg_bad
);

  localparam int             CNT_W = PSC_CNT_W;
  localparam int             A_PAD = B_W - A_W;
  localparam logic [B_W-1:0] B_MIN = B_W'(3);

  logic             ld_q, ld_d;
  logic             bad_q, bad_d;
  logic             fb_d;
  logic             cfg_ok;
  logic             boundary;
  logic             cap_go;
  logic             run;
  logic [CNT_W-1:0] cap_p;
  logic             psc_load;
  logic [CNT_W-1:0] psc_mod_m1;
  logic             psc_wrap;
  logic             period_end;

  always_comb begin
    cap_p    = psc_low_mod(psc_sel_e'(psel));
    cfg_ok   = ({{A_PAD{1'b0}}, div_a} <= div_b) && (div_b >= B_MIN);
    run      = !ld_q;
    boundary = ld_q || period_end;
    cap_go   = boundary && cfg_ok;

    ld_d  = ld_q;
    bad_d = bad_q;
    fb_d  = 1'b0;
    if (boundary) begin
      ld_d  = !cfg_ok;
      bad_d = !cfg_ok;
      fb_d  = period_end && cfg_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b1;
      bad_q <= 1'b0;
    end else if (boundary) begin
      ld_q  <= ld_d;
      bad_q <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_pulse <= 1'b0;
    else        fb_pulse <= fb_d;
  end

  assign cfg_bad = bad_q;

  pss_swallow_ctrl #(
    .A_W   (A_W),
    .B_W   (B_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (cap_go),
    .run        (run),
    .cap_a      (div_a),
    .cap_b      (div_b),
    .cap_p      (cap_p),
    .psc_wrap   (psc_wrap),
    .psc_load   (psc_load),
    .psc_mod_m1 (psc_mod_m1),
    .period_end (period_end)
  );

  pss_prescaler #(
    .CNT_W (CNT_W)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (psc_load),
    .mod_m1 (psc_mod_m1),
    .wrap   (psc_wrap)
  );

  pss_ref_div #(
    .R_W (R_W)
  ) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .ref_div   (ref_div),
    .ref_pulse (ref_pulse)
  );

  // R1
  fb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R5
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> !fb_pulse);

  // R5
  bad_resample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bad && cfg_ok) |=> !cfg_bad);

endmodule

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [5:0]  div_a = 6'd0;
  logic [11:0] div_b = 12'd3;
  logic [13:0] ref_div = 14'd1;
  logic        ref_tick = 1'b0;
  logic        fb_pulse, ref_pulse, cfg_bad;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";
  int tick_mode = 0;
  int cyc = 0;

  // behavioural model state
  bit m_ld = 1'b1;
  bit m_bad = 1'b0;
  bit m_fb = 1'b0;
  bit m_ref = 1'b0;
  int m_cnt = 0;
  int m_rcnt = 0;

  always #10 clk = ~clk;

  pulse_swallow_div u_pulse_swallow_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .div_a     (div_a),
    .div_b     (div_b),
    .ref_div   (ref_div),
    .ref_tick  (ref_tick),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse),
    .cfg_bad   (cfg_bad)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ld = 1'b1; m_bad = 1'b0; m_fb = 1'b0; m_ref = 1'b0;
      m_cnt = 0; m_rcnt = 0;
    end else begin
      int a, b, p, n, reff;
      bit ok;
      a = int'(div_a); b = int'(div_b); p = 8 << psel;
      n = b * p + a;
      ok = (b >= a) && (b >= 3);
      if (m_ld || m_cnt == 1) begin
        m_fb = !m_ld && ok;
        if (ok) begin m_ld = 1'b0; m_bad = 1'b0; m_cnt = n; end
        else    begin m_ld = 1'b1; m_bad = 1'b1; end
      end else begin
        m_fb = 1'b0;
        m_cnt = m_cnt - 1;
      end
      reff = (ref_div == 0) ? 1 : int'(ref_div);
      if (ref_tick) begin
        if (m_rcnt + 1 >= reff) begin m_rcnt = 0; m_ref = 1'b1; end
        else begin m_rcnt = m_rcnt + 1; m_ref = 1'b0; end
      end else begin
        m_ref = 1'b0;
      end
    end
  end

  task automatic check_bit(input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check_bit("fb_pulse", fb_pulse, m_fb);
      check_bit("ref_pulse", ref_pulse, m_ref);
      check_bit("cfg_bad", cfg_bad, m_bad);
      case (tick_mode)
        0: ref_tick = 1'b1;
        1: ref_tick = (cyc % 3) != 0;
        default: ref_tick = 1'b0;
      endcase
    end
  endtask

  task automatic set_cfg(input logic [1:0] s, input int a, input int b);
    psel = s; div_a = 6'(a); div_b = 12'(b);
  endtask

  task automatic wait_pulse_due(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (!m_ld && m_cnt == 1) break;
      run_cycles(1);
    end
  endtask

  task automatic count_pulses(input int n, input int exp_pulses, input string req);
    int got = 0;
    for (int i = 0; i < n; i++) begin
      run_cycles(1);
      if (fb_pulse === 1'b1) got++;
    end
    checks++;
    if (got != exp_pulses) begin
      errors++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", req, got, exp_pulses);
    end
  endtask

  initial begin
    // R6: reset state
    cur_req = "R6";
    run_cycles(4);
    rst_n = 1'b1;

    // R1 / R7: 8/9, A=5, B=10 -> N=85, ref divide 7
    cur_req = "R1";
    set_cfg(2'd0, 5, 10); ref_div = 14'd7; tick_mode = 0;
    run_cycles(2);
    // align to a pulse, then count pulses over 3 whole periods
    wait_pulse_due(200);
    run_cycles(1);
    cur_req = "R1";
    count_pulses(255, 3, "R1");

    // R2: each modulus pair, with mid-period changes (R4)
    cur_req = "R2";
    tick_mode = 1; ref_div = 14'd5;
    set_cfg(2'd1, 3, 4); run_cycles(300);
    set_cfg(2'd2, 3, 4); run_cycles(40);
    cur_req = "R4";
    set_cfg(2'd3, 3, 4); run_cycles(700);
    set_cfg(2'd2, 7, 9); run_cycles(30);
    set_cfg(2'd1, 1, 5); run_cycles(500);

    // R4: change exactly in the cycle before a pulse edge
    cur_req = "R4";
    wait_pulse_due(400);
    set_cfg(2'd0, 2, 6);
    run_cycles(120);

    // R5: illegal setting landing on a pulse edge, then B<3, then recovery
    cur_req = "R5";
    wait_pulse_due(200);
    set_cfg(2'd0, 5, 4);
    run_cycles(30);
    set_cfg(2'd1, 0, 2);
    run_cycles(20);
    set_cfg(2'd0, 4, 4);
    run_cycles(150);

    // R9: A=0 -> N = B*P
    cur_req = "R9";
    set_cfg(2'd0, 0, 3);
    wait_pulse_due(200);
    run_cycles(1);
    count_pulses(96, 4, "R9");

    // R8: ref divide value zero
    cur_req = "R8";
    ref_div = 14'd0; tick_mode = 1;
    run_cycles(60);
    tick_mode = 0;
    run_cycles(20);

    // R7: larger ref divide with gaps
    cur_req = "R7";
    ref_div = 14'd13; tick_mode = 1;
    run_cycles(200);

    // R3: widest counters, 8/9, A=63, B=4095 -> N=32823
    cur_req = "R3";
    set_cfg(2'd0, 63, 4095); tick_mode = 2;
    wait_pulse_due(200);
    run_cycles(1);
    count_pulses(32823, 1, "R3");
    run_cycles(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule